// File: doc/BRIEF.md
# Eight-Pin Port Output and Drive Controller

This block holds the software-visible state of one eight-pin general-purpose port and turns it into per-pin pad controls. Software reaches it over a plain 32-bit register bus with a byte address, a write strobe and a combinational read path. It keeps an output data value, which can be written whole or modified atomically through set, clear and invert alias addresses, a three-bit drive mode per pin, and an input-disable bit per pin.

From the mode and data of each pin the block produces a strong low driver enable, a strong high driver enable, a weak pull-up enable, a weak pull-down enable and an input buffer enable. The pad input is brought into the clock domain through two flops and is read back as pin state, forced to 0 on any pin whose input buffer is off. The upper byte of the drive configuration word holds analog and slew settings that are stored and read back but drive nothing here.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0 and all five pad control vectors are 0.
- R2: A write to offset 0x00 loads wdata[7:0] as the output data; a read of 0x00 returns it in bits [7:0] with bits [31:8] zero.
- R3: A write to 0x40 sets, to 0x44 clears and to 0x48 inverts each data bit whose wdata bit is 1, leaving bits with a wdata bit of 0 unchanged; reads of these three offsets return 0.
- R4: Offset 0x08 stores all 32 written bits and reads them back; pin i takes its drive mode from bits [3i+2:3i], and bits [31:24] have no effect on any output.
- R5: The strong low enable of a pin is 1 only in modes 2, 4 and 6 with data 0; the strong high enable is 1 only in modes 3, 5 and 6 with data 1; the two are never 1 together.
- R6: The weak pull-up is on in modes 2 and 7 and the weak pull-down in modes 3 and 7, whatever the data value.
- R7: Offset 0x18 holds the input-disable bits in [7:0]; a pin's input buffer enable is 1 exactly when its mode is not 0 and its disable bit is 0.
- R8: A read of 0x04 returns in bit i the pad input of pin i as sampled two clock edges earlier, AND-ed with that pin's input buffer enable; bits [31:8] read 0.
- R9: Reads of any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| pad_in | input | 8 | Raw pad input levels |
| pad_drv_lo | output | 8 | Strong low driver enable per pin |
| pad_drv_hi | output | 8 | Strong high driver enable per pin |
| pad_pu | output | 8 | Weak pull-up enable per pin |
| pad_pd | output | 8 | Weak pull-down enable per pin |
| pad_ie | output | 8 | Input buffer enable per pin |

## Verification
On every cycle the assertions check that no pin drives strong low and strong high at once, that the pin-state read never shows a 1 on a pin with its input buffer off, that each alias write changes exactly the selected data bits, and that the data holds without a write. The full mode decode table, the read-back of the stored configuration bits, the two-edge latency of the input path and the input-disable override can only be shown by the bench's directed and random scenarios, which compare every register and pad output with a model after each step.

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int NPINS = 8,
  parameter int MW    = 3,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_drv_lo,
  output logic [NPINS-1:0] pad_drv_hi,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd,
  output logic [NPINS-1:0] pad_ie
);
  localparam int MODEW = NPINS * MW;
  localparam logic [AW-1:0] A_DATA  = AW'(8'h00);
  localparam logic [AW-1:0] A_STATE = AW'(8'h04);
  localparam logic [AW-1:0] A_CFG   = AW'(8'h08);
  localparam logic [AW-1:0] A_INDIS = AW'(8'h18);
  localparam logic [AW-1:0] A_SET   = AW'(8'h40);
  localparam logic [AW-1:0] A_CLR   = AW'(8'h44);
  localparam logic [AW-1:0] A_INV   = AW'(8'h48);

  logic [NPINS-1:0] data_q, indis_q, sync1_q, sync2_q;
  logic [DW-1:0]    cfg_q;
  logic [NPINS-1:0] wbits;

  assign wbits = wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      indis_q <= '0;
      cfg_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DATA:  data_q  <= wbits;
        A_SET:   data_q  <= data_q | wbits;
        A_CLR:   data_q  <= data_q & ~wbits;
        A_INV:   data_q  <= data_q ^ wbits;
        A_CFG:   cfg_q   <= wdata;
        A_INDIS: indis_q <= wbits;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [MW-1:0] m;
    assign m = cfg_q[MW*i +: MW];
    assign pad_drv_lo[i] = ~data_q[i] & (m == 3'd2 || m == 3'd4 || m == 3'd6);
    assign pad_drv_hi[i] =  data_q[i] & (m == 3'd3 || m == 3'd5 || m == 3'd6);
    assign pad_pu[i]     = (m == 3'd2 || m == 3'd7);
    assign pad_pd[i]     = (m == 3'd3 || m == 3'd7);
    assign pad_ie[i]     = (m != '0) & ~indis_q[i];
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = DW'(data_q);
      A_STATE: rdata = DW'(sync2_q & pad_ie);
      A_CFG:   rdata = cfg_q;
      A_INDIS: rdata = DW'(indis_q);
      default: rdata = '0;
    endcase
  end

  if (MODEW > DW) begin : g_bad_width
    initial $error("mode field wider than data bus");
  end
endmodule

module gpio_port_ctrl_chk #(
  parameter int NPINS = 8,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic [NPINS-1:0] pad_drv_lo,
  input logic [NPINS-1:0] pad_drv_hi,
  input logic [NPINS-1:0] pad_ie,
  input logic [NPINS-1:0] dq
);
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_drv_lo & pad_drv_hi) == '0);

  p_state_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(8'h04)) |-> ((rdata[NPINS-1:0] & ~pad_ie) == '0 && rdata[DW-1:NPINS] == '0));

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h40)) |=> dq == ($past(dq) | $past(wdata[NPINS-1:0])));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h44)) |=> dq == ($past(dq) & ~$past(wdata[NPINS-1:0])));

  p_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h48)) |=> dq == ($past(dq) ^ $past(wdata[NPINS-1:0])));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(dq));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pad_drv_lo(pad_drv_lo), .pad_drv_hi(pad_drv_hi),
  .pad_ie(pad_ie), .dq(data_q)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0, pad_in = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0]  lo, hi, pu, pd, ie;
  int total = 0, bad = 0;

  logic [7:0]  m_data = 0, m_indis = 0;
  logic [31:0] m_cfg = 0;

  always #5 clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_drv_lo(lo), .pad_drv_hi(hi),
    .pad_pu(pu), .pad_pd(pd), .pad_ie(ie)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_ctl(logic [31:0] cfg, logic [7:0] d, logic [7:0] dis);
    logic [7:0] l, h, u, w, e;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] m;
      m = cfg[3*i +: 3];
      l[i] = ~d[i] & (m == 2 || m == 4 || m == 6);
      h[i] =  d[i] & (m == 3 || m == 5 || m == 6);
      u[i] = (m == 2 || m == 7);
      w[i] = (m == 3 || m == 7);
      e[i] = (m != 0) && !dis[i];
    end
    return {l, h, u, w, e};
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      8'h00: m_data = d[7:0];
      8'h40: m_data = m_data | d[7:0];
      8'h44: m_data = m_data & ~d[7:0];
      8'h48: m_data = m_data ^ d[7:0];
      8'h08: m_cfg = d;
      8'h18: m_indis = d[7:0];
      default: ;
    endcase
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
    addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic check_all(string tag);
    logic [39:0] c;
    c = exp_ctl(m_cfg, m_data, m_indis);
    rd_check({tag, " R2 data"}, 8'h00, {24'h0, m_data});
    rd_check({tag, " R4 cfg"}, 8'h08, m_cfg);
    rd_check({tag, " R7 indis"}, 8'h18, {24'h0, m_indis});
    check({tag, " R5 drv"}, {16'h0, lo, hi}, {16'h0, c[39:24]});
    check({tag, " R6 pulls"}, {16'h0, pu, pd}, {16'h0, c[23:8]});
    check({tag, " R7 ie"}, {24'h0, ie}, {24'h0, c[7:0]});
  endtask

  initial begin
    logic [39:0] c;
    logic [7:0] old_pad;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1: reset state
    rd_check("R1 data", 8'h00, 0);
    rd_check("R1 state", 8'h04, 0);
    rd_check("R1 cfg", 8'h08, 0);
    rd_check("R1 indis", 8'h18, 0);
    check("R1 pads", {lo, hi, pu, pd}, 0);
    check("R1 ie", {24'h0, ie}, 0);
    rst_n = 1;

    wr(8'h00, 32'hFFFF_FF5A); check_all("dir");
    rd_check("R3 set reads 0", 8'h40, 0);
    rd_check("R3 clr reads 0", 8'h44, 0);
    rd_check("R3 inv reads 0", 8'h48, 0);
    wr(8'h40, 32'h0000_0081); check_all("R3 set");
    wr(8'h44, 32'h0000_0018); check_all("R3 clr");
    wr(8'h48, 32'h0000_00F0); check_all("R3 inv");

    // R5/R6: each mode on pin 3 with both data values; upper cfg bits set (R4)
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 2; d++) begin
        wr(8'h08, 32'hA500_0000 | (32'(m) << 9));
        wr(8'h00, d ? 32'h08 : 32'h00);
        check_all("R5 R6 modes");
      end
    end

    // R7: input disable overrides mode
    wr(8'h08, 32'h00DB_6DB6);
    wr(8'h18, 32'h0000_0055);
    check_all("R7 disable");

    // R8: two-edge latency and masking
    pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    rd_check("R8 settled", 8'h04, {24'h0, 8'hFF & ie});
    old_pad = pad_in;
    pad_in = 8'h0F;
    @(negedge clk);
    rd_check("R8 one edge", 8'h04, {24'h0, old_pad & ie});
    @(negedge clk);
    rd_check("R8 two edges", 8'h04, {24'h0, 8'h0F & ie});
    wr(8'h08, 32'h0);
    rd_check("R8 mode0 reads 0", 8'h04, 0);

    // R9: undefined offsets
    wr(8'h00, 32'h3C);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    check_all("R9 undef write");
    rd_check("R9 undef read", 8'h20, 0);
    rd_check("R9 undef read", 8'hFC, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [7:0] a;
      op = $urandom_range(0, 7);
      case (op)
        0: a = 8'h00; 1: a = 8'h08; 2: a = 8'h18; 3: a = 8'h40;
        4: a = 8'h44; 5: a = 8'h48; 6: a = 8'h10; default: a = 8'h0C;
      endcase
      pad_in = 8'($urandom);
      wr(a, $urandom);
      repeat (2) @(negedge clk);
      check_all("rnd");
      c = exp_ctl(m_cfg, m_data, m_indis);
      rd_check("rnd R8 state", 8'h04, {24'h0, pad_in & c[7:0]});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule